// File: doc/BRIEF.md
# Bulk Payload Frame Slot Mapper

The block places a byte stream onto the bit slots of a serial bus frame laid out as rows and columns, and gathers bytes back from the same slots. A bus timing generator presents one bit slot per clock (frame start, row number and column number). In every row, only the columns from a programmable first column to a programmable last column carry payload. Column 0 is always left to the ordinary command channel. Bits leave most significant first: columns are taken in increasing order within a row, and rows in increasing order.

The configuration is captured at each frame start. From it the block derives the number of whole bytes the frame can hold, capped at 470. Window slots that lie past that last whole byte are driven as zero padding, so each frame carries a multiple of 8 payload bits. A per-byte-slot direction table marks bytes that the far end drives. For those bytes the block releases the line and assembles a received byte instead. A frame therefore carries either a write, with every byte sent, or a read, with a sent header and received data.

If the transmit stream has no byte ready when a send slot begins, the block fills that byte with zeros and raises an underrun pulse. An illegal window setting stops all payload movement for the whole frame and is reported.

Top module: `bulk_slot_mapper`

## Requirements
- R1: A slot in column 0 never carries payload: `bus_oe` is low in the cycle after any column-0 slot.
- R2: A window slot lies in a column from `cfg_hstart` to `cfg_hstop` inclusive and in a row below `cfg_rows`. For window slots, `bus_oe` and `bus_dout` appear one cycle after the slot. Each sent byte goes out most significant bit first, in increasing column order and then increasing row order.
- R3: A frame's byte budget is min(floor(rows × (hstop − hstart + 1) / 8), 470). Window slots after budget × 8 bits are padding: they are driven (`bus_oe` high) with `bus_dout` low.
- R4: Window, row count, column count and direction table are sampled at the slot with `frame_start` high. Changing them later in that frame has no effect on it.
- R5: A configuration is illegal when hstart = 0, hstart > hstop, or hstop ≥ `cfg_cols`. For such a frame, `cfg_err` is high from the cycle after frame start until the next frame start, and the block does all of the following:
  - it never raises `tx_ready`;
  - it delivers no received byte;
  - it keeps `bus_oe` low.

  For a legal frame, `cfg_err` is low.
- R6: `tx_ready` is high, combinationally, exactly during the first bit slot of each byte slot that is sent. A byte is taken when `tx_valid` is also high.
- R7: If `tx_valid` is low while `tx_ready` is high, that byte slot is sent as eight zeros and `tx_underrun` pulses high for one cycle, one cycle after the slot.
- R8: Bit i of `cfg_rx_dir` set to 1 marks byte slot i as received; byte slots at or beyond the table depth use the top bit. For a received slot, `bus_oe` is low one cycle later.
- R9: A received byte appears on `rx_data` with `rx_valid` high for one cycle. This happens one cycle after its eighth bit slot, with the first received bit in bit 7.
- R10: After reset, and until the first frame start, `bus_oe`, `bus_dout`, `tx_ready`, `tx_underrun`, `rx_valid` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bit slot per cycle when `slot_en` is high |
| rst | input | 1 | Synchronous active-high reset |
| slot_en | input | 1 | A bit slot is presented this cycle |
| frame_start | input | 1 | This slot is row 0, column 0 of a new frame |
| slot_row | input | ROW_W | Row number of the slot |
| slot_col | input | COL_W | Column number of the slot |
| cfg_hstart | input | COL_W | First payload column |
| cfg_hstop | input | COL_W | Last payload column |
| cfg_cols | input | COL_W+1 | Columns per row |
| cfg_rows | input | ROW_W+1 | Rows per frame |
| cfg_rx_dir | input | DIR_DEPTH | Per-byte-slot direction, 1 = far end drives |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken this cycle if valid |
| bus_din | input | 1 | Received line value for the current slot |
| bus_dout | output | 1 | Line value for the previous slot |
| bus_oe | output | 1 | Drive enable for the previous slot |
| tx_underrun | output | 1 | Previous byte start had no transmit byte |
| rx_valid | output | 1 | Received byte valid |
| rx_data | output | 8 | Received byte |
| cfg_err | output | 1 | Current frame configuration is illegal |

## Verification
`tx_ready` is combinational on the presented slot, so the bench checks it one time unit after driving that slot. Line drive, padding, underrun and direction all come out of a single register stage. The bench keeps its predictions for each slot and compares them at the falling edge after the next rising edge, before it drives the following slot. A received byte is compared at that same falling edge after its eighth slot. `cfg_err` is checked once the frame has ended, and it then holds for the whole frame.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

    localparam int unsigned DEF_COL_W     = 4;
    localparam int unsigned DEF_ROW_W     = 8;
    localparam int unsigned DEF_DIR_DEPTH = 8;
    localparam int unsigned DEF_MAX_BYTES = 470;

    typedef enum logic [1:0] {
        SLOT_IDLE = 2'd0,
        SLOT_TX   = 2'd1,
        SLOT_RX   = 2'd2,
        SLOT_PAD  = 2'd3
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic       first;
        logic       last;
    } slot_t;

    function automatic logic cfg_illegal(input int unsigned hs,
                                         input int unsigned he,
                                         input int unsigned cols);
        return (hs == 0) || (hs > he) || (he >= cols);
    endfunction

    function automatic int unsigned frame_bytes(input int unsigned rows,
                                                input int unsigned hs,
                                                input int unsigned he,
                                                input int unsigned cap);
        int unsigned bytes;
        if (hs > he) return 0;
        bytes = (rows * (he - hs + 1)) / 8;
        return (bytes > cap) ? cap : bytes;
    endfunction

endpackage

// File: rtl/bsm_cfg_latch.sv
module bsm_cfg_latch
    import bsm_pkg::*;
#(
    parameter int unsigned COL_W     = DEF_COL_W,
    parameter int unsigned ROW_W     = DEF_ROW_W,
    parameter int unsigned DIR_DEPTH = DEF_DIR_DEPTH,
    parameter int unsigned MAX_BYTES = DEF_MAX_BYTES,
    parameter int unsigned CNT_W     = ROW_W + COL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample,
    input  logic [COL_W-1:0]     in_hstart,
    input  logic [COL_W-1:0]     in_hstop,
    input  logic [COL_W:0]       in_cols,
    input  logic [ROW_W:0]       in_rows,
    input  logic [DIR_DEPTH-1:0] in_dir,
    output logic [COL_W-1:0]     hs_q,
    output logic [COL_W-1:0]     he_q,
    output logic [ROW_W:0]       rows_q,
    output logic [DIR_DEPTH-1:0] dir_q,
    output logic [CNT_W-1:0]     budget_q,
    output logic                 ok_q,
    output logic                 err_q
);

    logic             bad_n;
    logic [CNT_W-1:0] budget_n;

    always_comb begin
        bad_n    = cfg_illegal(32'(in_hstart), 32'(in_hstop), 32'(in_cols));
        budget_n = CNT_W'(8 * frame_bytes(32'(in_rows), 32'(in_hstart),
                                          32'(in_hstop), MAX_BYTES));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q     <= '0;
            he_q     <= '0;
            rows_q   <= '0;
            dir_q    <= '0;
            budget_q <= '0;
            ok_q     <= 1'b0;
            err_q    <= 1'b0;
        end else if (sample) begin
            hs_q     <= in_hstart;
            he_q     <= in_hstop;
            rows_q   <= in_rows;
            dir_q    <= in_dir;
            budget_q <= bad_n ? '0 : budget_n;
            ok_q     <= !bad_n;
            err_q    <= bad_n;
        end
    end

    // R3: a legal frame never claims more than the byte cap
    p_budget_cap_r3: assert property (@(posedge clk) disable iff (rst)
        ok_q |-> (32'(budget_q) <= MAX_BYTES * 8));

endmodule

// File: rtl/bsm_slot_decode.sv
module bsm_slot_decode
    import bsm_pkg::*;
#(
    parameter int unsigned COL_W     = DEF_COL_W,
    parameter int unsigned ROW_W     = DEF_ROW_W,
    parameter int unsigned DIR_DEPTH = DEF_DIR_DEPTH,
    parameter int unsigned MAX_BYTES = DEF_MAX_BYTES,
    parameter int unsigned CNT_W     = ROW_W + COL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 slot_en,
    input  logic                 frame_start,
    input  logic [ROW_W-1:0]     row,
    input  logic [COL_W-1:0]     col,
    input  logic [COL_W-1:0]     hs_q,
    input  logic [COL_W-1:0]     he_q,
    input  logic [ROW_W:0]       rows_q,
    input  logic [DIR_DEPTH-1:0] dir_q,
    input  logic [CNT_W-1:0]     budget_q,
    input  logic                 ok_q,
    output slot_t                slot
);

    localparam int unsigned IDX_W  = CNT_W - 3;
    localparam int unsigned DSEL_W = (DIR_DEPTH > 1) ? $clog2(DIR_DEPTH) : 1;

    logic [CNT_W-1:0] bit_cnt;
    logic [IDX_W-1:0] byte_idx;
    logic             in_win;
    logic             far_drives;

    assign byte_idx = bit_cnt[CNT_W-1:3];

    always_comb begin
        in_win = slot_en && !frame_start && ok_q &&
                 (col >= hs_q) && (col <= he_q) &&
                 ({1'b0, row} < rows_q);
        if (32'(byte_idx) >= DIR_DEPTH)
            far_drives = dir_q[DIR_DEPTH-1];
        else
            far_drives = dir_q[byte_idx[DSEL_W-1:0]];

        slot.first = (bit_cnt[2:0] == 3'd0);
        slot.last  = (bit_cnt[2:0] == 3'd7);
        if (!in_win)
            slot.kind = SLOT_IDLE;
        else if (bit_cnt >= budget_q)
            slot.kind = SLOT_PAD;
        else if (far_drives)
            slot.kind = SLOT_RX;
        else
            slot.kind = SLOT_TX;
    end

    always_ff @(posedge clk) begin
        if (rst)
            bit_cnt <= '0;
        else if (slot_en && frame_start)
            bit_cnt <= '0;
        else if (in_win)
            bit_cnt <= bit_cnt + 1'b1;
    end

    // R1: the command column is never inside the payload window
    p_col0_outside_r1: assert property (@(posedge clk) disable iff (rst)
        (slot.kind != SLOT_IDLE) |-> (col != '0));

    // R3: payload bytes never reach the per-frame cap
    p_cap_r3: assert property (@(posedge clk) disable iff (rst)
        (slot.kind == SLOT_TX || slot.kind == SLOT_RX) |->
            (32'(byte_idx) < MAX_BYTES));

endmodule

// File: rtl/bsm_tx_serializer.sv
module bsm_tx_serializer
    import bsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_t      slot,
    input  logic       tx_valid,
    input  logic [7:0] tx_data,
    output logic       tx_ready,
    output logic       bus_dout,
    output logic       bus_oe,
    output logic       tx_underrun
);

    logic [7:0] sh;

    assign tx_ready = (slot.kind == SLOT_TX) && slot.first;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh          <= '0;
            bus_dout    <= 1'b0;
            bus_oe      <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            bus_oe      <= (slot.kind == SLOT_TX) || (slot.kind == SLOT_PAD);
            tx_underrun <= tx_ready && !tx_valid;
            if (slot.kind == SLOT_TX) begin
                if (slot.first) begin
                    if (tx_valid) begin
                        bus_dout <= tx_data[7];
                        sh       <= {tx_data[6:0], 1'b0};
                    end else begin
                        bus_dout <= 1'b0;
                        sh       <= '0;
                    end
                end else begin
                    bus_dout <= sh[7];
                    sh       <= {sh[6:0], 1'b0};
                end
            end else begin
                bus_dout <= 1'b0;
            end
        end
    end

    // R3: padding slots are driven low
    p_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (slot.kind == SLOT_PAD) |=> (bus_oe && !bus_dout));

    // R7: a starved byte start sends zero and flags underrun
    p_underrun_r7: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !tx_valid) |=> (tx_underrun && !bus_dout));

    // R8: received slots release the line
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        (slot.kind == SLOT_RX) |=> !bus_oe);

endmodule

// File: rtl/bsm_rx_deserializer.sv
module bsm_rx_deserializer
    import bsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_t      slot,
    input  logic       bus_din,
    output logic       rx_valid,
    output logic [7:0] rx_data
);

    logic [6:0] rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sh    <= '0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (slot.kind == SLOT_RX) begin
                rx_sh <= {rx_sh[5:0], bus_din};
                if (slot.last) begin
                    rx_valid <= 1'b1;
                    rx_data  <= {rx_sh, bus_din};
                end
            end
        end
    end

    // R9: received bytes are single-cycle pulses, never back to back
    p_rx_spacing_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

endmodule

// File: rtl/bulk_slot_mapper.sv
module bulk_slot_mapper
    import bsm_pkg::*;
#(
    parameter int unsigned COL_W     = DEF_COL_W,
    parameter int unsigned ROW_W     = DEF_ROW_W,
    parameter int unsigned DIR_DEPTH = DEF_DIR_DEPTH,
    parameter int unsigned MAX_BYTES = DEF_MAX_BYTES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 slot_en,
    input  logic                 frame_start,
    input  logic [ROW_W-1:0]     slot_row,
    input  logic [COL_W-1:0]     slot_col,
    input  logic [COL_W-1:0]     cfg_hstart,
    input  logic [COL_W-1:0]     cfg_hstop,
    input  logic [COL_W:0]       cfg_cols,
    input  logic [ROW_W:0]       cfg_rows,
    input  logic [DIR_DEPTH-1:0] cfg_rx_dir,
    input  logic                 tx_valid,
    input  logic [7:0]           tx_data,
    output logic                 tx_ready,
    input  logic                 bus_din,
    output logic                 bus_dout,
    output logic                 bus_oe,
    output logic                 tx_underrun,
    output logic                 rx_valid,
    output logic [7:0]           rx_data,
    output logic                 cfg_err
);

    localparam int unsigned CNT_W = ROW_W + COL_W + 1;

    logic [COL_W-1:0]     hs_q;
    logic [COL_W-1:0]     he_q;
    logic [ROW_W:0]       rows_q;
    logic [DIR_DEPTH-1:0] dir_q;
    logic [CNT_W-1:0]     budget_q;
    logic                 ok_q;
    slot_t                slot;

    bsm_cfg_latch #(
        .COL_W(COL_W), .ROW_W(ROW_W), .DIR_DEPTH(DIR_DEPTH),
        .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .sample(slot_en && frame_start),
        .in_hstart(cfg_hstart), .in_hstop(cfg_hstop), .in_cols(cfg_cols),
        .in_rows(cfg_rows), .in_dir(cfg_rx_dir),
        .hs_q(hs_q), .he_q(he_q), .rows_q(rows_q), .dir_q(dir_q),
        .budget_q(budget_q), .ok_q(ok_q), .err_q(cfg_err)
    );

    bsm_slot_decode #(
        .COL_W(COL_W), .ROW_W(ROW_W), .DIR_DEPTH(DIR_DEPTH),
        .MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)
    ) u_dec (
        .clk(clk), .rst(rst), .slot_en(slot_en), .frame_start(frame_start),
        .row(slot_row), .col(slot_col), .hs_q(hs_q), .he_q(he_q),
        .rows_q(rows_q), .dir_q(dir_q), .budget_q(budget_q), .ok_q(ok_q),
        .slot(slot)
    );

    bsm_tx_serializer u_tx (
        .clk(clk), .rst(rst), .slot(slot), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .tx_underrun(tx_underrun)
    );

    bsm_rx_deserializer u_rx (
        .clk(clk), .rst(rst), .slot(slot), .bus_din(bus_din),
        .rx_valid(rx_valid), .rx_data(rx_data)
    );

    // R1: a column-0 slot leaves the line released
    p_col0_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (slot_en && slot_col == '0) |=> !bus_oe);

    // R5: an illegal frame never asks for transmit bytes
    p_no_move_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !tx_ready);

    // R5: an illegal frame never delivers received bytes
    p_no_rx_r5: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> !rx_valid);

endmodule

// File: tb/bulk_slot_mapper_test.sv
module bulk_slot_mapper_test;

    localparam int COL_W = 4;
    localparam int ROW_W = 8;
    localparam int DIRD  = 8;
    localparam int CAP   = 470;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             slot_en = 1'b0;
    logic             frame_start = 1'b0;
    logic [ROW_W-1:0] slot_row = '0;
    logic [COL_W-1:0] slot_col = '0;
    logic [COL_W-1:0] cfg_hstart = '0;
    logic [COL_W-1:0] cfg_hstop = '0;
    logic [COL_W:0]   cfg_cols = '0;
    logic [ROW_W:0]   cfg_rows = '0;
    logic [DIRD-1:0]  cfg_rx_dir = '0;
    logic             tx_valid = 1'b0;
    logic [7:0]       tx_data = '0;
    logic             tx_ready;
    logic             bus_din = 1'b0;
    logic             bus_dout;
    logic             bus_oe;
    logic             tx_underrun;
    logic             rx_valid;
    logic [7:0]       rx_data;
    logic             cfg_err;

    always #2 clk = ~clk;

    bulk_slot_mapper uut (
        .clk(clk), .rst(rst), .slot_en(slot_en), .frame_start(frame_start),
        .slot_row(slot_row), .slot_col(slot_col), .cfg_hstart(cfg_hstart),
        .cfg_hstop(cfg_hstop), .cfg_cols(cfg_cols), .cfg_rows(cfg_rows),
        .cfg_rx_dir(cfg_rx_dir), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .bus_din(bus_din), .bus_dout(bus_dout),
        .bus_oe(bus_oe), .tx_underrun(tx_underrun), .rx_valid(rx_valid),
        .rx_data(rx_data), .cfg_err(cfg_err)
    );

    int nchk = 0;
    int nerr = 0;
    bit starve [0:511];

    bit     p_have;
    bit     p_oe, p_dout, p_und, p_rxv;
    logic [7:0] p_rxd;
    string  p_tag;

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_prev();
        if (p_have) begin
            chk({p_tag, " bus_oe"}, int'(bus_oe), int'(p_oe));
            chk({p_tag, " bus_dout"}, int'(bus_dout), int'(p_dout));
            chk("R7 tx_underrun", int'(tx_underrun), int'(p_und));
            chk("R9 rx_valid", int'(rx_valid), int'(p_rxv));
            if (p_rxv) chk("R9 rx_data", int'(rx_data), int'(p_rxd));
        end
    endtask

    function automatic int model_budget(int rows, int hs, int he);
        int b;
        if (hs > he) return 0;
        b = (rows * (he - hs + 1)) / 8;
        return (b > CAP) ? CAP : b;
    endfunction

    task automatic clear_starve();
        for (int i = 0; i < 512; i++) starve[i] = 1'b0;
    endtask

    task automatic run_frame(input int rows, input int cols, input int hs,
                             input int he, input logic [DIRD-1:0] dir,
                             input bit mutate);
        bit   ok;
        int   budget_bits, bc, bidx, bp;
        bit   win, pay, rxd, rdy, starved;
        logic [7:0] cur, rsh;
        cfg_hstart = COL_W'(hs);
        cfg_hstop  = COL_W'(he);
        cfg_cols   = (COL_W+1)'(cols);
        cfg_rows   = (ROW_W+1)'(rows);
        cfg_rx_dir = dir;
        ok = !(hs == 0 || hs > he || he >= cols);
        budget_bits = ok ? 8 * model_budget(rows, hs, he) : 0;
        bc = 0; cur = '0; rsh = '0; starved = 1'b0;
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                @(negedge clk);
                check_prev();
                slot_en     = 1'b1;
                frame_start = (r == 0 && c == 0);
                slot_row    = ROW_W'(r);
                slot_col    = COL_W'(c);
                if (mutate && r == 1 && c == 0) begin
                    cfg_hstart = '0;
                    cfg_hstop  = COL_W'(cols - 1);
                    cfg_rows   = '1;
                    cfg_cols   = '1;
                    cfg_rx_dir = ~dir;
                end
                win  = ok && !(r == 0 && c == 0) && c >= hs && c <= he;
                pay  = win && (bc < budget_bits);
                bidx = bc / 8;
                bp   = bc % 8;
                rxd  = dir[(bidx >= DIRD) ? DIRD - 1 : bidx];
                rdy  = pay && !rxd && bp == 0;
                bus_din = 1'($urandom_range(1, 0));
                tx_data = 8'($urandom_range(255, 0));
                if (rdy) begin
                    starved  = starve[bidx];
                    tx_valid = !starved;
                    cur      = starved ? 8'h00 : tx_data;
                end else begin
                    tx_valid = 1'($urandom_range(1, 0));
                end
                #1;
                chk(ok ? "R6 tx_ready" : "R5 tx_ready", int'(tx_ready), int'(rdy));
                p_have = 1'b1;
                p_oe   = win && !(pay && rxd);
                p_dout = (pay && !rxd) ? cur[7 - bp] : 1'b0;
                p_und  = rdy && starved;
                p_rxv  = 1'b0;
                if (pay && rxd) begin
                    rsh = {rsh[6:0], bus_din};
                    if (bp == 7) begin
                        p_rxv = 1'b1;
                        p_rxd = rsh;
                    end
                end
                if (c == 0)            p_tag = "R1";
                else if (!ok)          p_tag = "R5";
                else if (mutate)       p_tag = "R4";
                else if (win && !pay)  p_tag = "R3";
                else if (pay && rxd)   p_tag = "R8";
                else                   p_tag = "R2";
                if (win) bc++;
            end
        end
        @(negedge clk);
        check_prev();
        p_have = 1'b0;
        slot_en = 1'b0;
        frame_start = 1'b0;
        tx_valid = 1'b0;
        chk("R5 cfg_err", int'(cfg_err), int'(!ok));
        cfg_hstart = COL_W'(hs);
        cfg_hstop  = COL_W'(he);
        cfg_cols   = (COL_W+1)'(cols);
        cfg_rows   = (ROW_W+1)'(rows);
        cfg_rx_dir = dir;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog R10 actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int seed_discard;
        seed_discard = $urandom(32'd20240611);
        p_have = 1'b0;
        clear_starve();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 bus_oe", int'(bus_oe), 0);
        chk("R10 bus_dout", int'(bus_dout), 0);
        chk("R10 tx_underrun", int'(tx_underrun), 0);
        chk("R10 rx_valid", int'(rx_valid), 0);
        chk("R10 cfg_err", int'(cfg_err), 0);
        // R10 slots before any frame start move nothing
        cfg_hstart = 4'd1; cfg_hstop = 4'd7; cfg_cols = 5'd8; cfg_rows = 9'd4;
        for (int i = 0; i < 6; i++) begin
            slot_en = 1'b1; slot_col = COL_W'(i + 1); slot_row = '0;
            tx_valid = 1'b1;
            #1 chk("R10 tx_ready", int'(tx_ready), 0);
            @(negedge clk);
            chk("R10 bus_oe idle", int'(bus_oe), 0);
        end
        slot_en = 1'b0; tx_valid = 1'b0;
        @(negedge clk);

        // R2 full-bandwidth window, all bytes sent
        run_frame(8, 16, 1, 15, 8'h00, 1'b0);
        // R3 narrow window with 4 padding bits
        run_frame(5, 10, 3, 6, 8'h00, 1'b0);
        // R8 mixed directions, top entry covers bytes 7 and up
        run_frame(10, 12, 2, 11, 8'b1000_0110, 1'b0);
        // R7 starved byte slots 2 and 5
        clear_starve();
        starve[2] = 1'b1; starve[5] = 1'b1;
        run_frame(6, 16, 1, 15, 8'h00, 1'b0);
        clear_starve();
        // R5 illegal windows
        run_frame(4, 8, 0, 5, 8'h00, 1'b0);
        run_frame(4, 8, 6, 3, 8'h00, 1'b0);
        run_frame(4, 8, 2, 8, 8'h00, 1'b0);
        // R5 a legal frame right after clears the flag
        run_frame(3, 8, 1, 7, 8'h0F, 1'b0);
        // R4 configuration changed mid-frame
        run_frame(6, 14, 2, 12, 8'b0001_0000, 1'b1);
        // R3 byte cap: 256 rows of 15 columns is 480 bytes, capped at 470
        run_frame(256, 16, 1, 15, 8'h00, 1'b0);
        // random frames
        for (int k = 0; k < 8; k++) begin
            int cols, hs, he, rows;
            logic [DIRD-1:0] dir;
            cols = $urandom_range(16, 4);
            hs   = $urandom_range(cols - 1, 1);
            he   = $urandom_range(cols - 1, hs);
            rows = $urandom_range(12, 1);
            dir  = DIRD'($urandom_range(255, 0));
            for (int i = 0; i < 64; i++) starve[i] = ($urandom_range(7, 0) == 0);
            run_frame(rows, cols, hs, he, dir, 1'b0);
        end
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule